// File: doc/BRIEF.md
# DMA Channel Address and Word-Count Engine

This block keeps the transfer bookkeeping for a single DMA channel. It has a current address register and a current word-count register. Each of them has a base register that keeps the value the processor last wrote. Each transfer strobe moves the address one step, up or down, and lowers the count by one. The count underflowing from zero to all ones marks terminal count, so a programmed count N yields N+1 transfers.

An end-of-process event is either a terminal count or an external end-of-process input. On such an event the engine does one of two things. If autoinitialize is selected, it reloads the current registers from their base copies. Otherwise it pulses a request for the surrounding controller to set the channel's mask bit.

The processor side moves data one byte at a time. An external byte pointer picks the low or the high byte of each access, and the engine answers every access with a one-cycle toggle pulse so that the pointer can advance. When the engine is built as the first channel, a memory-to-memory hold option freezes the address while the count keeps stepping. Bus timing, data movement and arbitration belong to other blocks.

Top module: `dma_chan_engine`

## Requirements
- R1: While `rstN` is low, all four address and count registers clear to zero, and `tcPulse`, `maskReq` and `ptrToggle` go low.
- R2: A write with `wrAddr` (or `wrCount`) high stores `wrData` into one byte of both the current and the base register. `bytePtr`=0 selects bits 7:0 and `bytePtr`=1 selects bits 15:8. A write takes priority over a transfer strobe or end-of-process in the same cycle, and those are then ignored.
- R3: `rdData` shows, without a clock cycle of delay, the byte of the current address (`rdAddr`) or the current count (`rdCount`) that `bytePtr` selects. If neither read is high, it shows zero. The base registers are never visible.
- R4: `ptrToggle` is high for exactly the one cycle that follows any cycle with a byte read or byte write, provided `masterClr` was low in that earlier cycle.
- R5: Each accepted `xferStb` adds one to the current address when `addrDec`=0 and subtracts one when `addrDec`=1, both modulo 2^16.
- R6: Each accepted `xferStb` lowers the current count by one. `tcPulse` is high in the cycle after a strobe that found the count at 0000h. A programmed count N therefore gives N+1 transfers.
- R7: If `autoInitEn` is 0, an end-of-process pulses `maskReq` in the following cycle. After terminal count the count then reads FFFFh.
- R8: If `autoInitEn` is 1, an end-of-process copies both base registers into the current registers in place of the step, and raises no `maskReq`. Steps never change the base registers.
- R9: `eopIn` without a terminal count causes the same autoinitialize or mask-request action and does not raise `tcPulse`.
- R10: With `memToMem` and `addrHoldEn` both 1 on a hold-capable channel, a strobe leaves the address unchanged and still steps the count.
- R11: A cycle with `masterClr` high changes neither the current nor the base registers, ignores writes, strobes and end-of-process, and produces no pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterClr | input | 1 | Software master clear; freezes values for the cycle |
| wrAddr | input | 1 | Write one byte of address (current and base) |
| wrCount | input | 1 | Write one byte of word count (current and base) |
| rdAddr | input | 1 | Read one byte of current address |
| rdCount | input | 1 | Read one byte of current word count |
| bytePtr | input | 1 | Byte select: 0 low byte, 1 high byte |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte |
| ptrToggle | output | 1 | One-cycle pulse after each byte access |
| xferStb | input | 1 | One transfer completed |
| eopIn | input | 1 | External end-of-process |
| autoInitEn | input | 1 | Mode: reload from base on end-of-process |
| addrDec | input | 1 | Mode: 1 decrements the address, 0 increments it |
| memToMem | input | 1 | Memory-to-memory operation active |
| addrHoldEn | input | 1 | Address hold for memory-to-memory |
| tcPulse | output | 1 | Terminal count reached (one cycle) |
| maskReq | output | 1 | Request to set this channel's mask bit (one cycle) |

## Verification
The checker watches several behaviours on every cycle. It confirms the toggle that follows each byte access and that terminal count only follows a strobe that found a zero count. It also confirms the FFFFh count left after a terminal count without autoinitialize, that `maskReq` and autoinitialize are mutually exclusive, the frozen address under hold, and that master clear leaves the registers unchanged. Other behaviours show only through the bench's scenarios, which compare values read back through `rdData` against a reference model. These are the exact byte placement of writes, the step direction and wrap of the address, the N+1 transfer count, the reload of the base values, and writes taking priority over strobes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadAddr;   // byte write into address pair
    logic loadCount;  // byte write into count pair
    logic step;       // count steps down by one
    logic moveAddr;   // address steps by one
    logic dec;        // address direction
    logic reload;     // copy base into current
  } chanStb_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter bit HOLD_CAPABLE = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     masterClr,
  input  logic     wrAddr,
  input  logic     wrCount,
  input  logic     rdAddr,
  input  logic     rdCount,
  input  logic     xferStb,
  input  logic     eopIn,
  input  logic     autoInitEn,
  input  logic     addrDec,
  input  logic     memToMem,
  input  logic     addrHoldEn,
  input  logic     countZero,
  output chanStb_t stb,
  output logic     tcPulse,
  output logic     maskReq,
  output logic     ptrToggle
);
  logic anyWr;
  logic live;
  logic tcHit;
  logic eopHit;
  logic holdAddr;

  always_comb begin
    anyWr    = wrAddr | wrCount;
    live     = !masterClr && !anyWr;
    tcHit    = live && xferStb && countZero;
    eopHit   = tcHit || (live && eopIn);
    holdAddr = HOLD_CAPABLE && memToMem && addrHoldEn;

    stb.loadAddr  = !masterClr && wrAddr;
    stb.loadCount = !masterClr && wrCount;
    stb.reload    = eopHit && autoInitEn;
    stb.step      = live && xferStb && !stb.reload;
    stb.moveAddr  = stb.step && !holdAddr;
    stb.dec       = addrDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcPulse   <= 1'b0;
      maskReq   <= 1'b0;
      ptrToggle <= 1'b0;
    end else begin
      tcPulse   <= tcHit;
      maskReq   <= eopHit && !autoInitEn;
      ptrToggle <= !masterClr && (anyWr || rdAddr || rdCount);
    end
  end
endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic [PTR_W-1:0]  bytePtr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdAddr,
  input  logic              rdCount,
  output logic [BYTE_W-1:0] rdData,
  output logic [DATA_W-1:0] curAddr,
  output logic [DATA_W-1:0] curCount,
  output logic              countZero
);
  logic [DATA_W-1:0] baseAddr, baseCount;
  logic [DATA_W-1:0] curAddrWr, curCountWr, baseAddrWr, baseCountWr;
  logic [DATA_W-1:0] rdSel;

  // Merge the write byte into each register at the selected lane.
  always_comb begin
    curAddrWr   = curAddr;
    curCountWr  = curCount;
    baseAddrWr  = baseAddr;
    baseCountWr = baseCount;
    for (int i = 0; i < NB; i++) begin
      if (PTR_W'(i) == bytePtr) begin
        curAddrWr[i*BYTE_W +: BYTE_W]   = wrData;
        curCountWr[i*BYTE_W +: BYTE_W]  = wrData;
        baseAddrWr[i*BYTE_W +: BYTE_W]  = wrData;
        baseCountWr[i*BYTE_W +: BYTE_W] = wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curCount  <= '0;
      baseAddr  <= '0;
      baseCount <= '0;
    end else begin
      if (stb.loadAddr) begin
        curAddr  <= curAddrWr;
        baseAddr <= baseAddrWr;
      end else if (stb.reload) begin
        curAddr <= baseAddr;
      end else if (stb.moveAddr) begin
        curAddr <= stb.dec ? curAddr - 1'b1 : curAddr + 1'b1;
      end

      if (stb.loadCount) begin
        curCount  <= curCountWr;
        baseCount <= baseCountWr;
      end else if (stb.reload) begin
        curCount <= baseCount;
      end else if (stb.step) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  always_comb begin
    countZero = (curCount == '0);
    rdSel     = rdAddr ? curAddr : curCount;
    rdData    = (rdAddr || rdCount) ? rdSel[bytePtr*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int BYTE_W       = 8,
  parameter bit HOLD_CAPABLE = 1'b1,
  localparam int NB          = DATA_W / BYTE_W,
  localparam int PTR_W       = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterClr,
  input  logic              wrAddr,
  input  logic              wrCount,
  input  logic              rdAddr,
  input  logic              rdCount,
  input  logic [PTR_W-1:0]  bytePtr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              ptrToggle,
  input  logic              xferStb,
  input  logic              eopIn,
  input  logic              autoInitEn,
  input  logic              addrDec,
  input  logic              memToMem,
  input  logic              addrHoldEn,
  output logic              tcPulse,
  output logic              maskReq
);
  chanStb_t          stb;
  logic              countZero;
  logic [DATA_W-1:0] curAddr;
  logic [DATA_W-1:0] curCount;

  dma_chan_ctrl #(.HOLD_CAPABLE(HOLD_CAPABLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .masterClr(masterClr),
    .wrAddr(wrAddr), .wrCount(wrCount), .rdAddr(rdAddr), .rdCount(rdCount),
    .xferStb(xferStb), .eopIn(eopIn), .autoInitEn(autoInitEn),
    .addrDec(addrDec), .memToMem(memToMem), .addrHoldEn(addrHoldEn),
    .countZero(countZero), .stb(stb),
    .tcPulse(tcPulse), .maskReq(maskReq), .ptrToggle(ptrToggle)
  );

  dma_chan_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bytePtr(bytePtr), .wrData(wrData),
    .rdAddr(rdAddr), .rdCount(rdCount), .rdData(rdData),
    .curAddr(curAddr), .curCount(curCount), .countZero(countZero)
  );
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int DATA_W       = 16,
  parameter bit HOLD_CAPABLE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterClr,
  input logic              wrAddr,
  input logic              wrCount,
  input logic              rdAddr,
  input logic              rdCount,
  input logic              xferStb,
  input logic              eopIn,
  input logic              autoInitEn,
  input logic              memToMem,
  input logic              addrHoldEn,
  input logic              tcPulse,
  input logic              maskReq,
  input logic              ptrToggle,
  input logic [DATA_W-1:0] curAddr,
  input logic [DATA_W-1:0] curCount
);
  a_r4_toggle_after_access: assert property (@(posedge clk) disable iff (!rstN)
    (!masterClr && (wrAddr || wrCount || rdAddr || rdCount)) |=> ptrToggle);

  a_r6_tc_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> ($past(xferStb) && $past(curCount) == '0));

  a_r7_count_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse && maskReq) |-> (curCount == '1));

  a_r8_reload_or_mask: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> (maskReq != $past(autoInitEn)));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (HOLD_CAPABLE && xferStb && memToMem && addrHoldEn && !masterClr &&
     !wrAddr && !wrCount && !eopIn && !autoInitEn) |=> $stable(curAddr));

  a_r11_mclr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> ($stable(curAddr) && $stable(curCount) && !tcPulse && !maskReq));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.DATA_W(DATA_W), .HOLD_CAPABLE(HOLD_CAPABLE)) i_chk (
  .clk(clk), .rstN(rstN), .masterClr(masterClr), .wrAddr(wrAddr), .wrCount(wrCount),
  .rdAddr(rdAddr), .rdCount(rdCount), .xferStb(xferStb), .eopIn(eopIn),
  .autoInitEn(autoInitEn), .memToMem(memToMem), .addrHoldEn(addrHoldEn),
  .tcPulse(tcPulse), .maskReq(maskReq), .ptrToggle(ptrToggle),
  .curAddr(curAddr), .curCount(curCount)
);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterClr = 1'b0, wrAddr = 1'b0, wrCount = 1'b0, rdAddr = 1'b0, rdCount = 1'b0;
  logic [0:0] bytePtr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ptrToggle, tcPulse, maskReq;
  logic       xferStb = 1'b0, eopIn = 1'b0, autoInitEn = 1'b0, addrDec = 1'b0;
  logic       memToMem = 1'b0, addrHoldEn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mAddr = '0, mCount = '0, mBaseA = '0, mBaseC = '0;

  dma_chan_engine i_dma_chan_engine (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .wrAddr(wrAddr), .wrCount(wrCount),
    .rdAddr(rdAddr), .rdCount(rdCount), .bytePtr(bytePtr), .wrData(wrData),
    .rdData(rdData), .ptrToggle(ptrToggle), .xferStb(xferStb), .eopIn(eopIn),
    .autoInitEn(autoInitEn), .addrDec(addrDec), .memToMem(memToMem),
    .addrHoldEn(addrHoldEn), .tcPulse(tcPulse), .maskReq(maskReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // R2: write one byte of address or count; R4: toggle follows
  task automatic wrByte(input bit isAddr, input bit b, input logic [7:0] d);
    wrAddr = isAddr; wrCount = !isAddr; bytePtr = b; wrData = d;
    cyc();
    wrAddr = 1'b0; wrCount = 1'b0;
    chk("R4 toggle after write", ptrToggle, 1'b1);
    if (isAddr) begin mAddr[b*8 +: 8] = d; mBaseA[b*8 +: 8] = d; end
    else        begin mCount[b*8 +: 8] = d; mBaseC[b*8 +: 8] = d; end
  endtask

  task automatic wrWord(input bit isAddr, input logic [15:0] v);
    wrByte(isAddr, 1'b0, v[7:0]);
    wrByte(isAddr, 1'b1, v[15:8]);
  endtask

  // R3: combinational byte readback
  task automatic rdWord(input bit isAddr, output logic [15:0] v);
    for (int b = 0; b < 2; b++) begin
      rdAddr = isAddr; rdCount = !isAddr; bytePtr = b[0];
      #1 v[b*8 +: 8] = rdData;
      cyc();
    end
    rdAddr = 1'b0; rdCount = 1'b0;
  endtask

  task automatic chkRegs(input string tag);
    logic [15:0] v;
    rdWord(1'b1, v); chk({tag, " address"}, v, mAddr);
    rdWord(1'b0, v); chk({tag, " count"}, v, mCount);
  endtask

  // Expected outcome of one strobe/eop cycle (R5..R10)
  task automatic xfer(input bit s, input bit e, input string tag);
    bit tcE, eopE, maskE, hold;
    tcE   = s && (mCount == 16'h0000);
    eopE  = tcE || e;
    maskE = eopE && !autoInitEn;
    hold  = memToMem && addrHoldEn;
    if (eopE && autoInitEn) begin
      mAddr = mBaseA; mCount = mBaseC;
    end else if (s) begin
      if (!hold) mAddr = addrDec ? mAddr - 16'd1 : mAddr + 16'd1;
      mCount = mCount - 16'd1;
    end
    xferStb = s; eopIn = e;
    cyc();
    xferStb = 1'b0; eopIn = 1'b0;
    chk({tag, " tcPulse"}, tcPulse, tcE);
    chk({tag, " maskReq"}, maskReq, maskE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int tcCount;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tcPulse at reset", tcPulse, 1'b0);
    chk("R1 maskReq at reset", maskReq, 1'b0);
    chk("R1 ptrToggle at reset", ptrToggle, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkRegs("R1 reset value");
    chk("R3 idle rdData zero", rdData, 8'h00);

    // R2/R3: byte placement
    wrWord(1'b1, 16'hA55A);
    wrWord(1'b0, 16'h1234);
    chkRegs("R2 word write");
    wrByte(1'b1, 1'b1, 8'h3C);
    chkRegs("R2 high byte only");

    // R6/R7: count of 2 gives 3 transfers, wraps to FFFF, mask request
    autoInitEn = 1'b0; addrDec = 1'b0;
    wrWord(1'b0, 16'h0002);
    wrWord(1'b1, 16'hFFFE);
    tcCount = 0;
    for (int i = 0; i < 3; i++) begin
      xfer(1'b1, 1'b0, "R6 N+1 transfers");
      if (tcPulse) tcCount++;
    end
    chk("R6 one tc after N+1 strobes", tcCount, 1);
    chkRegs("R5 R7 address wrap and count FFFF");
    chk("R7 count FFFF value", mCount, 16'hFFFF);

    // R5: decrement direction
    addrDec = 1'b1;
    wrWord(1'b1, 16'h0001);
    xfer(1'b1, 1'b0, "R5 decrement");
    xfer(1'b1, 1'b0, "R5 decrement past zero");
    chkRegs("R5 decrement wrap");

    // R8: autoinitialize on terminal count
    autoInitEn = 1'b1; addrDec = 1'b0;
    wrWord(1'b1, 16'h4000);
    wrWord(1'b0, 16'h0001);
    xfer(1'b1, 1'b0, "R8 step");
    xfer(1'b1, 1'b0, "R8 tc with reload");
    chkRegs("R8 reloaded from base");

    // R9: external eop
    xfer(1'b1, 1'b0, "R9 setup step");
    xfer(1'b0, 1'b1, "R9 eop reload");
    chkRegs("R9 eop restored");
    autoInitEn = 1'b0;
    xfer(1'b0, 1'b1, "R9 eop mask request");

    // R10: address hold
    memToMem = 1'b1; addrHoldEn = 1'b1;
    wrWord(1'b0, 16'h0010);
    xfer(1'b1, 1'b0, "R10 hold");
    xfer(1'b1, 1'b0, "R10 hold");
    chkRegs("R10 address held");
    memToMem = 1'b0; addrHoldEn = 1'b0;

    // R2: write beats strobe in the same cycle
    wrAddr = 1'b1; bytePtr = 1'b0; wrData = 8'h77; xferStb = 1'b1;
    cyc();
    wrAddr = 1'b0; xferStb = 1'b0;
    mAddr[7:0] = 8'h77; mBaseA[7:0] = 8'h77;
    chk("R2 write priority tc", tcPulse, 1'b0);
    chkRegs("R2 write priority");

    // R11: master clear with strobe, eop and write
    wrWord(1'b0, 16'h0000);
    masterClr = 1'b1; xferStb = 1'b1; eopIn = 1'b1; wrCount = 1'b1; wrData = 8'hEE;
    cyc();
    masterClr = 1'b0; xferStb = 1'b0; eopIn = 1'b0; wrCount = 1'b0;
    chk("R11 no tc", tcPulse, 1'b0);
    chk("R11 no mask", maskReq, 1'b0);
    chk("R11 R4 no toggle", ptrToggle, 1'b0);
    chkRegs("R11 values kept");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) wrWord(1'b0, 16'($urandom % 6));
      else if (op == 1) wrWord(1'b1, 16'($urandom));
      else if (op == 2) begin
        autoInitEn = 1'($urandom); addrDec = 1'($urandom);
        memToMem = 1'($urandom); addrHoldEn = 1'($urandom);
        @(negedge clk);
      end else if (op == 3) chkRegs("R5 R6 random readback");
      else xfer(1'b1, ($urandom % 8) == 0, "R6 R9 random");
    end
    chkRegs("R8 final readback");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule